// File: doc/BRIEF.md
# Bit-Serial Adder/Subtractor

This block adds or subtracts two WIDTH-bit operands one bit position per clock, using a single full-adder cell and a one-bit carry register instead of a WIDTH-wide carry chain. It suits places where area counts for more than latency. The operands are captured in parallel into two right-shifting registers. Each cycle the low bit of each operand, the mode-adjusted second operand bit and the stored carry feed the full adder. The sum bit enters the top of a third shift register, and the carry-out is kept for the next bit position.

A request is offered with `op_valid` and taken when `op_ready` is high in the same cycle. `op_ready` is low for the whole computation. This is the only back-pressure the block applies: a request offered while `op_ready` is low is not taken and has no effect, so the requester must keep `op_valid` high until it sees `op_ready`. The result side has no back-pressure. `res_done` pulses for one cycle, and `res_sum`/`res_carry` then stay unchanged until the next request is taken.

In subtract mode the second operand is inverted bit by bit and the carry register is forced to one when the request is taken. This forms A + ~B + 1. In add mode the carry register is forced to zero.

Top module: `serial_adder`

## Requirements
- R1: After reset, `op_ready` is 1, `res_done` is 0, `res_sum` is 0 and `res_carry` is 0.
- R2: A request is taken on a rising edge where `op_valid` and `op_ready` are both 1. `op_ready` is 0 in the cycle that follows and stays 0 until the result is delivered.
- R3: `res_done` is 1 for exactly one cycle, WIDTH clock cycles after the edge that took the request. `op_ready` is 1 again in that same cycle.
- R4: With `op_sub`=0, `res_sum` equals (A+B) mod 2^WIDTH, and `res_carry` is bit WIDTH of the (WIDTH+1)-bit sum A+B.
- R5: With `op_sub`=1, `res_sum` equals (A−B) mod 2^WIDTH, and `res_carry` is bit WIDTH of A + ~B + 1, so it is 1 exactly when A ≥ B (unsigned, no borrow).
- R6: `op_valid` asserted while `op_ready` is 0 is ignored. The operands, the mode and the delivered result are those of the request already in progress.
- R7: From the `res_done` cycle until the next request is taken, `res_sum` and `res_carry` do not change.
- R8: A request held on `op_valid` is taken in the same cycle that `res_done` is high, so consecutive results appear WIDTH+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Request offered |
| op_ready | output | 1 | Block can take a request this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract (A−B) |
| op_a | input | WIDTH | First operand A |
| op_b | input | WIDTH | Second operand B |
| res_done | output | 1 | One-cycle pulse: result valid |
| res_sum | output | WIDTH | Sum or difference, held after `res_done` |
| res_carry | output | 1 | Final carry (add) or no-borrow flag (subtract) |

## Verification
Two functions can fall in the same cycle: delivering one result and taking the next request. This happens when a request is already waiting as the final bit position completes. The bench provokes it by holding `op_valid` high over several operations. It judges the overlap by the spacing of WIDTH+1 cycles between `res_done` pulses and by comparing each delivered value with its arithmetic reference. A second overlap is also exercised: a request arriving mid-computation with different operands and mode must leave the running result untouched.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } mode_e;

  // Full adder written with generate / xor-propagate terms so that the
  // sum and carry paths share the same first-level xor and stay balanced.
  function automatic logic [1:0] fa_bit(input logic a, input logic b, input logic cin);
    logic gen;
    logic pxor;
    gen  = a & b;
    pxor = a ^ b;
    return {gen | (pxor & cin), pxor ^ cin};
  endfunction

endpackage

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);

  // Right shift: bit 0 leaves first, ser_in enters at the top.
  generate
    if (WIDTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= ser_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {ser_in, q[WIDTH-1:1]};
      end
    end
  endgenerate

endmodule

// File: rtl/sadd_carry_ff.sv
module sadd_carry_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  input  logic en,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (en)  q <= d;
  end

endmodule

// File: rtl/sadd_bitcell.sv
module sadd_bitcell (
  input  logic a_bit,
  input  logic b_bit,
  input  logic cin,
  input  logic invert_b,
  output logic sum,
  output logic cout
);
  import sadd_pkg::*;

  logic [1:0] fa_out;

  always_comb begin
    fa_out = fa_bit(a_bit, b_bit ^ invert_b, cin);
  end

  assign sum  = fa_out[0];
  assign cout = fa_out[1];

endmodule

// File: rtl/sadd_ctrl.sv
module sadd_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] bit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      bit_idx <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (bit_idx == LAST) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          bit_idx <= '0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end else if (start) begin
        busy    <= 1'b1;
        bit_idx <= '0;
      end
    end
  end

endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic             op_sub,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             res_done,
  output logic [WIDTH-1:0] res_sum,
  output logic             res_carry
);
  import sadd_pkg::*;

  logic             busy;
  logic             accept;
  mode_e            mode_q;
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q;
  logic [WIDTH-1:0] r_q;
  logic             carry_q;
  logic             sum_bit;
  logic             cout_bit;

  assign op_ready = ~busy;
  assign accept   = op_valid & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= MODE_ADD;
    else if (accept) mode_q <= op_sub ? MODE_SUB : MODE_ADD;
  end

  sadd_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy),
    .done  (res_done)
  );

  sadd_shreg #(.WIDTH(WIDTH)) u_reg_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (op_a),
    .shift    (busy),
    .ser_in   (1'b0),
    .q        (a_q)
  );

  sadd_shreg #(.WIDTH(WIDTH)) u_reg_b (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (op_b),
    .shift    (busy),
    .ser_in   (1'b0),
    .q        (b_q)
  );

  sadd_shreg #(.WIDTH(WIDTH)) u_reg_r (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val ({WIDTH{1'b0}}),
    .shift    (busy),
    .ser_in   (sum_bit),
    .q        (r_q)
  );

  sadd_bitcell u_cell (
    .a_bit    (a_q[0]),
    .b_bit    (b_q[0]),
    .cin      (carry_q),
    .invert_b (mode_q == MODE_SUB),
    .sum      (sum_bit),
    .cout     (cout_bit)
  );

  sadd_carry_ff u_carry (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept & ~op_sub),
    .set   (accept & op_sub),
    .en    (busy),
    .d     (cout_bit),
    .q     (carry_q)
  );

  assign res_sum   = r_q;
  assign res_carry = carry_q;

endmodule

// File: rtl/sadd_chk.sv
module sadd_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic             res_done,
  input logic [WIDTH-1:0] res_sum,
  input logic             res_carry
);

  localparam int CW = $clog2(WIDTH + 1) + 1;

  logic          run;
  logic [CW-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      since <= '0;
    end else if (op_valid && op_ready) begin
      run   <= 1'b1;
      since <= '0;
    end else if (res_done) begin
      run   <= 1'b0;
    end else if (run) begin
      since <= since + 1'b1;
    end
  end

  // R2: a taken request drops op_ready on the next cycle
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> !op_ready);

  // R3: done lasts one cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  // R3: ready returns together with done
  a_r3_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> op_ready);

  // R3: done lands exactly WIDTH cycles after acceptance
  a_r3_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (run && since == CW'(WIDTH)));

  // R7: idle without a request keeps the result stable
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ready && !op_valid) |=> ($stable(res_sum) && $stable(res_carry)));

endmodule

bind serial_adder sadd_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_serial_adder.sv
`timescale 1ns/1ps
module tb_serial_adder;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic         op_sub = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         op_ready;
  logic         res_done;
  logic [W-1:0] res_sum;
  logic         res_carry;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  serial_adder #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_sub(op_sub), .op_a(op_a), .op_b(op_b), .res_done(res_done),
    .res_sum(res_sum), .res_carry(res_carry)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  bit           m_busy;
  int           m_left;
  bit           m_done;
  logic [W-1:0] m_sum;
  bit           m_carry;
  bit           m_mode;
  logic [W:0]   m_pend;
  bit           m_pend_mode;

  function automatic logic [W:0] ref_calc(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub);
    if (sub) return {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
    return {1'b0, a} + {1'b0, b};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_busy <= 0; m_left <= 0; m_done <= 0; m_sum <= '0; m_carry <= 0; m_mode <= 0;
    end else begin
      m_done <= 0;
      if (!m_busy && op_valid) begin
        m_busy      <= 1;
        m_left      <= W;
        m_pend      <= ref_calc(op_a, op_b, op_sub);
        m_pend_mode <= op_sub;
      end else if (m_busy) begin
        if (m_left == 1) begin
          m_busy  <= 0;
          m_done  <= 1;
          m_sum   <= m_pend[W-1:0];
          m_carry <= m_pend[W];
          m_mode  <= m_pend_mode;
        end
        m_left <= m_left - 1;
      end
    end
  end

  // Every-clock comparison, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(op_ready == !m_busy, "R2 op_ready", op_ready, !m_busy);
      chk(res_done == m_done, "R3 res_done timing", res_done, m_done);
      if (!m_busy) begin
        if (res_done) begin
          chk(res_sum == m_sum, m_mode ? "R5 difference" : "R4 sum", res_sum, m_sum);
          chk(res_carry == m_carry, m_mode ? "R5 no-borrow" : "R4 carry", res_carry, m_carry);
        end else begin
          chk(res_sum == m_sum && res_carry == m_carry, "R7 held result",
              {res_carry, res_sum}, {m_carry, m_sum});
        end
      end
    end
  end

  task automatic wait_done();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!res_done && guard < 4 * W + 10);
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1; op_a = a; op_b = b; op_sub = sub;
    @(negedge clk);
    op_valid = 0;
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(op_ready == 1'b1, "R1 op_ready in reset", op_ready, 1);
    chk(res_done == 1'b0, "R1 res_done in reset", res_done, 0);
    chk(res_sum == '0, "R1 res_sum in reset", res_sum, 0);
    chk(res_carry == 1'b0, "R1 res_carry in reset", res_carry, 0);
    rst_n = 1;
    @(negedge clk);
    chk(op_ready == 1'b1 && res_sum == '0, "R1 state after reset", {op_ready, res_sum}, {1'b1, 8'h00});

    // R4 directed adds
    run_op(8'h00, 8'h00, 0);
    run_op(8'h01, 8'h7f, 0);
    run_op(8'hff, 8'h01, 0);
    chk(res_sum == 8'h00 && res_carry, "R4 wrap with carry", {res_carry, res_sum}, 9'h100);
    run_op(8'hff, 8'hff, 0);
    run_op(8'h5a, 8'ha5, 0);
    // R5 directed subtracts
    run_op(8'h05, 8'h03, 1);
    chk(res_sum == 8'h02 && res_carry, "R5 5-3", {res_carry, res_sum}, 9'h102);
    run_op(8'h03, 8'h05, 1);
    chk(res_sum == 8'hfe && !res_carry, "R5 3-5 borrow", {res_carry, res_sum}, 9'h0fe);
    run_op(8'h00, 8'h00, 1);
    run_op(8'h80, 8'h01, 1);
    run_op(8'h00, 8'hff, 1);

    // R6 request during computation is ignored
    @(negedge clk);
    op_valid = 1; op_a = 8'h11; op_b = 8'h22; op_sub = 0;
    @(negedge clk);
    op_a = 8'hee; op_b = 8'h01; op_sub = 1;
    repeat (3) @(negedge clk);
    op_valid = 0;
    wait_done();
    chk(res_sum == 8'h33 && !res_carry, "R6 ignored mid-op request", {res_carry, res_sum}, 9'h033);
    repeat (2) @(negedge clk);
    chk(op_ready == 1'b1, "R6 no extra operation started", op_ready, 1);

    // R7 idle hold
    repeat (5) @(negedge clk);
    chk(res_sum == 8'h33, "R7 held after idle", res_sum, 8'h33);

    // R8 back-to-back: request held across done
    begin
      int t0;
      int t1;
      @(negedge clk);
      op_valid = 1; op_a = 8'h10; op_b = 8'h20; op_sub = 0;
      wait_done();
      t0 = cyc;
      wait_done();
      t1 = cyc;
      chk(t1 - t0 == W + 1, "R8 back-to-back spacing", t1 - t0, W + 1);
      op_valid = 0;
      wait_done();
    end

    // Random operations, mixed modes
    for (int i = 0; i < 300; i++) begin
      run_op(W'($urandom), W'($urandom), bit'($urandom_range(0, 1)));
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule